// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models, in synthesizable form, a small serial EEPROM as a bus master sees it. The master raises chip select and then clocks a start bit, a two-bit opcode, an address and, for some commands, a data word into the serial input. The slave answers reads on a data output that has its own output-enable. It keeps a write-enable latch that gates every programming command, and it runs a self-timed programming cycle from a cycle counter. An organization input selects 16-bit words or 8-bit bytes over the same storage.

All pins are sampled on the system clock `clk`. The serial clock is edge-detected internally, so its rising edges must be separated by several system clocks. A synchronous reset stands in for power-on. After reset the write-enable latch is clear and the output is disabled. While chip select is high after a programming command has been launched, the output reports busy or ready.

Top module: `sep3w_slave`

## Requirements
- R1: Bits are taken from `di` on rising `sclk` edges. A start is the first rising edge with `cs` and `di` both high; any zero bits clocked before it have no effect.
- R2: After the start bit, the opcode is two bits, MSB first: 10 READ, 01 WRITE, 11 ERASE. Opcode 00 takes its meaning from the two most significant address bits: 11 enable programming, 00 disable programming, 10 erase all, 01 write all. The address follows MSB first and is ABITS-1 bits wide when `org16`=1 and ABITS bits wide when `org16`=0. Data follows MSB first.
- R3: After the last READ address bit, `do_en` is high and `do_q` is 0 (dummy bit). Each following rising `sclk` edge presents the next bit of the addressed word, MSB first: 16 bits when `org16`=1, 8 bits when `org16`=0.
- R4: While `cs` stays high after the LSB of a read word, the address increments, wrapping from the top address to 0, and the next word follows at once with no dummy bit.
- R5: The write-enable latch is clear after reset and after the disable command. While it is clear, WRITE, ERASE, erase-all and write-all change no data and start no programming cycle. READ works whatever the latch holds.
- R6: WRITE stores the shifted word at the address. Programming starts on the falling edge of `cs` after the last data bit. Extra `sclk` edges between the last bit and that edge are ignored.
- R7: ERASE sets every bit of the addressed word to 1.
- R8: Erase-all sets every bit of the array to 1. Write-all writes the shifted word to every address.
- R9: A command whose bits are not all shifted in before `cs` falls is discarded.
- R10: When `cs` is raised after a programming cycle has been launched, `do_en` is high. `do_q` reads 0 for about PROG_CYCLES system clocks and then 1, until the next start bit.
- R11: `do_en` is low after reset, and it is low two system clocks after `cs` falls.
- R12: In 8-bit mode, byte address 2k holds the high byte and 2k+1 the low byte of 16-bit word k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on stand-in) |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, rising edge samples `di` |
| di | input | 1 | Serial data in |
| org16 | input | 1 | 1 selects 16-bit words, 0 selects 8-bit bytes |
| do_q | output | 1 | Serial data out value |
| do_en | output | 1 | Output enable for `do_q` (low means high impedance) |

## Verification
The assertions take for granted that `cs`, `sclk` and `di` change away from `clk` edges and that `sclk` stays in each level for several system clocks, so that one serial edge is seen as exactly one detected rise. They also assume `org16` is steady while a command is in progress. The bench drives every pin on the falling edge of `clk` and holds each serial phase for six system clocks. It changes `org16` only while `cs` is low, and it issues no new command until the ready status has been seen.

// File: rtl/sep3w_pkg.sv
package sep3w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_RDOUT, ST_DONE
  } st_t;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_ERASE = 2'b11;
  localparam logic [1:0] OPC_EXT   = 2'b00;

  localparam logic [1:0] EXT_EN    = 2'b11;
  localparam logic [1:0] EXT_DIS   = 2'b00;
  localparam logic [1:0] EXT_ERALL = 2'b10;
  localparam logic [1:0] EXT_WRALL = 2'b01;
endpackage

// File: rtl/sep3w_sync.sv
module sep3w_sync (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sclk,
  input  logic di,
  output logic cs_q,
  output logic di_q,
  output logic sclk_rise,
  output logic cs_fall
);
  logic sclk_q, sclk_p, cs_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b0;
      di_q   <= 1'b0;
      sclk_q <= 1'b0;
      sclk_p <= 1'b0;
      cs_p   <= 1'b0;
    end else begin
      cs_q   <= cs;
      di_q   <= di;
      sclk_q <= sclk;
      sclk_p <= sclk_q;
      cs_p   <= cs_q;
    end
  end

  assign sclk_rise = sclk_q & ~sclk_p;
  assign cs_fall   = ~cs_q & cs_p;
endmodule

// File: rtl/sep3w_array.sv
module sep3w_array #(
  parameter int IDXW  = 7,
  parameter int BYTEW = 8
) (
  input  logic               clk,
  input  logic               we,
  input  logic [1:0]         wmask,
  input  logic [IDXW-1:0]    widx,
  input  logic [2*BYTEW-1:0] wdata,
  input  logic [IDXW-1:0]    ridx,
  output logic [2*BYTEW-1:0] rdata
);
  localparam int DEPTH = 1 << IDXW;

  // bank 1 holds the high byte (even byte address), bank 0 the low byte
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [BYTEW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wmask[b]) mem[widx] <= wdata[b*BYTEW +: BYTEW];
      rdata[b*BYTEW +: BYTEW] <= mem[ridx];
    end
  end
endmodule

// File: rtl/sep3w_timer.sv
module sep3w_timer #(
  parameter int IDXW        = 7,
  parameter int PROG_CYCLES = 400
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            bulk,
  output logic            busy,
  output logic            bulk_q,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx
);
  localparam int DEPTH    = 1 << IDXW;
  localparam int BULK_CYC = (PROG_CYCLES > DEPTH) ? PROG_CYCLES : DEPTH + 1;
  localparam int CW       = $clog2(BULK_CYC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = bulk_q ? CW'(BULK_CYC - 1) : CW'(PROG_CYCLES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      bulk_q <= 1'b0;
      cnt    <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        bulk_q <= bulk;
        cnt    <= '0;
      end
    end else if (cnt == last) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign wr_en  = busy && (bulk_q ? (cnt < CW'(DEPTH)) : (cnt == '0));
  assign wr_idx = cnt[IDXW-1:0];
endmodule

// File: rtl/sep3w_slave.sv
module sep3w_slave
  import sep3w_pkg::*;
#(
  parameter int ABITS       = 8,
  parameter int PROG_CYCLES = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sclk,
  input  logic di,
  input  logic org16,
  output logic do_q,
  output logic do_en
);
  localparam int IDXW = ABITS - 1;

  logic cs_q, di_q, sclk_rise, cs_fall;
  st_t  st;
  logic [4:0]       bitcnt;
  logic [1:0]       opc;
  logic [ABITS-1:0] addr_sh, addr_nx, cur_addr;
  logic [15:0]      data_sh, data_nx, out_sh, rd_word, rdata;
  logic             wel, stat, pend, pend_bulk;
  logic [15:0]      p_data;
  logic [1:0]       p_mask;
  logic [IDXW-1:0]  p_idx, rd_idx, mem_idx, t_idx;
  logic             t_busy, t_bulk, t_we, prog_go;
  logic [4:0]       addr_last, data_last;
  logic [1:0]       top2;

  sep3w_sync u_sync (
    .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .di(di),
    .cs_q(cs_q), .di_q(di_q), .sclk_rise(sclk_rise), .cs_fall(cs_fall)
  );

  function automatic logic [IDXW-1:0] word_idx(input logic x16, input logic [ABITS-1:0] a);
    return x16 ? a[IDXW-1:0] : a[ABITS-1:1];
  endfunction

  function automatic logic [1:0] byte_mask(input logic x16, input logic [ABITS-1:0] a);
    return x16 ? 2'b11 : (a[0] ? 2'b01 : 2'b10);
  endfunction

  assign addr_last = org16 ? 5'(ABITS - 2) : 5'(ABITS - 1);
  assign data_last = org16 ? 5'd15 : 5'd7;
  assign addr_nx   = {addr_sh[ABITS-2:0], di_q};
  assign data_nx   = {data_sh[14:0], di_q};
  assign top2      = org16 ? addr_nx[ABITS-2 -: 2] : addr_nx[ABITS-1 -: 2];
  assign prog_go   = cs_fall && (st == ST_DONE) && pend && wel && !t_busy;

  assign rd_idx  = word_idx(org16, cur_addr);
  assign rd_word = org16 ? rdata : {(cur_addr[0] ? rdata[7:0] : rdata[15:8]), 8'h00};
  assign mem_idx = t_bulk ? t_idx : p_idx;

  sep3w_timer #(.IDXW(IDXW), .PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(prog_go), .bulk(pend_bulk),
    .busy(t_busy), .bulk_q(t_bulk), .wr_en(t_we), .wr_idx(t_idx)
  );

  sep3w_array #(.IDXW(IDXW), .BYTEW(8)) u_array (
    .clk(clk), .we(t_we), .wmask(p_mask), .widx(mem_idx), .wdata(p_data),
    .ridx(rd_idx), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      bitcnt    <= '0;
      opc       <= '0;
      addr_sh   <= '0;
      data_sh   <= '0;
      out_sh    <= '0;
      cur_addr  <= '0;
      wel       <= 1'b0;
      stat      <= 1'b0;
      pend      <= 1'b0;
      pend_bulk <= 1'b0;
      p_data    <= '0;
      p_mask    <= '0;
      p_idx     <= '0;
      do_q      <= 1'b0;
      do_en     <= 1'b0;
    end else if (!cs_q) begin
      st    <= ST_IDLE;
      do_en <= 1'b0;
      pend  <= 1'b0;
      if (prog_go) stat <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          do_en <= stat;
          do_q  <= ~t_busy;
          if (sclk_rise && di_q && !t_busy) begin
            st      <= ST_OPC;
            bitcnt  <= '0;
            addr_sh <= '0;
            stat    <= 1'b0;
            do_en   <= 1'b0;
          end
        end
        ST_OPC: if (sclk_rise) begin
          opc <= {opc[0], di_q};
          if (bitcnt == 5'd1) begin
            st     <= ST_ADDR;
            bitcnt <= '0;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_ADDR: if (sclk_rise) begin
          addr_sh <= addr_nx;
          if (bitcnt == addr_last) begin
            cur_addr <= org16 ? {1'b0, addr_nx[ABITS-2:0]} : addr_nx;
            bitcnt   <= '0;
            st       <= ST_DONE;
            case (opc)
              OPC_READ: begin
                st    <= ST_RDOUT;
                do_en <= 1'b1;
                do_q  <= 1'b0;
              end
              OPC_WRITE: st <= ST_DATA;
              OPC_ERASE: begin
                pend      <= 1'b1;
                pend_bulk <= 1'b0;
                p_data    <= '1;
                p_idx     <= word_idx(org16, addr_nx);
                p_mask    <= byte_mask(org16, addr_nx);
              end
              default: begin
                case (top2)
                  EXT_EN:  wel <= 1'b1;
                  EXT_DIS: wel <= 1'b0;
                  EXT_ERALL: begin
                    pend      <= 1'b1;
                    pend_bulk <= 1'b1;
                    p_data    <= '1;
                    p_mask    <= 2'b11;
                  end
                  default: st <= ST_DATA;
                endcase
              end
            endcase
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_DATA: if (sclk_rise) begin
          data_sh <= data_nx;
          if (bitcnt == data_last) begin
            st     <= ST_DONE;
            pend   <= 1'b1;
            p_data <= org16 ? data_nx : {data_nx[7:0], data_nx[7:0]};
            if (opc == OPC_EXT) begin
              pend_bulk <= 1'b1;
              p_mask    <= 2'b11;
            end else begin
              pend_bulk <= 1'b0;
              p_idx     <= word_idx(org16, cur_addr);
              p_mask    <= byte_mask(org16, cur_addr);
            end
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_RDOUT: if (sclk_rise) begin
          if (bitcnt == '0) begin
            do_q   <= rd_word[15];
            out_sh <= {rd_word[14:0], 1'b0};
            bitcnt <= data_last;
          end else begin
            do_q   <= out_sh[15];
            out_sh <= {out_sh[14:0], 1'b0};
            bitcnt <= bitcnt - 1'b1;
            if (bitcnt == 5'd1)
              cur_addr <= org16 ? {1'b0, cur_addr[IDXW-1:0] + IDXW'(1)}
                                : cur_addr + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sep3w_chk.sv
module sep3w_chk
  import sep3w_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic cs,
  input logic cs_q,
  input logic sclk_rise,
  input logic do_q,
  input logic do_en,
  input logic busy,
  input logic wel,
  input st_t  st
);
  // R11: output disabled once cs has been low long enough to pass the input stage
  p_oe_off_r11: assert property (@(posedge clk) disable iff (rst)
    (!cs && $past(!cs) && $past(!cs, 2)) |-> !do_en);

  // R6: programming cycles begin only after cs has gone low
  p_prog_cs_low_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(cs_q));

  // R5: no programming cycle without the write-enable latch
  p_prog_needs_wel_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> wel);

  // R3: read output begins with the dummy zero
  p_dummy_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RDOUT && $past(st) != ST_RDOUT) |-> (do_en && !do_q));

  // R3: read bits change only after a detected serial rise
  p_rd_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RDOUT && $past(st == ST_RDOUT) && !$past(sclk_rise)) |-> $stable(do_q));

  // R10: status shows busy while the cycle is running
  p_busy_low_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && do_en && busy && $past(busy)) |-> !do_q);
endmodule

bind sep3w_slave sep3w_chk u_chk (
  .clk(clk), .rst(rst), .cs(cs), .cs_q(cs_q), .sclk_rise(sclk_rise),
  .do_q(do_q), .do_en(do_en), .busy(t_busy), .wel(wel), .st(st)
);

// File: tb/sep3w_slave_bench.sv
module sep3w_slave_bench;
  localparam int ABITS = 8;
  localparam int PROG  = 400;
  localparam int PHASE = 6;

  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sclk = 1'b0, di = 1'b0, org16 = 1'b1;
  logic do_q, do_en;
  int n_run = 0, n_fail = 0;
  logic [7:0] mdl [256];
  bit done = 1'b0;

  always #10 clk = ~clk;

  sep3w_slave #(.ABITS(ABITS), .PROG_CYCLES(PROG)) u_sep3w_slave (
    .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .di(di), .org16(org16),
    .do_q(do_q), .do_en(do_en)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input bit x16, input int a);
    if (x16) return {mdl[2*a], mdl[2*a+1]};
    return {8'h00, mdl[a]};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    di = b;
    wait_clk(PHASE);
    sclk = 1'b1;
    wait_clk(PHASE);
    sclk = 1'b0;
  endtask

  task automatic cs_low();
    cs = 1'b0; di = 1'b0;
    wait_clk(PHASE);
  endtask

  task automatic send_cmd(input logic [1:0] op, input int a, input int aw, input int lead);
    cs = 1'b1;
    wait_clk(PHASE);
    for (int i = 0; i < lead; i++) bit_out(1'b0);
    bit_out(1'b1);
    bit_out(op[1]);
    bit_out(op[0]);
    for (int i = aw - 1; i >= 0; i--) bit_out(a[i]);
  endtask

  task automatic send_data(input int d, input int w);
    for (int i = w - 1; i >= 0; i--) bit_out(d[i]);
  endtask

  // R10: busy then ready on the output after raising cs
  task automatic wait_ready(input string tag);
    int n = 0;
    cs = 1'b1;
    wait_clk(PHASE);
    check(do_en === 1'b1 && do_q === 1'b0, {"R10 busy ", tag}, {do_en, do_q}, 2'b10);
    while (do_q !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(n + 12 >= PROG && n + 12 <= PROG + 8, {"R10 time ", tag}, n + 12, PROG);
    cs_low();
  endtask

  task automatic do_read(input bit x16, input int a, input int nw, input string tag);
    int aw = x16 ? ABITS - 1 : ABITS;
    int w  = x16 ? 16 : 8;
    int cur = a;
    org16 = x16;
    send_cmd(2'b10, a, aw, 0);
    @(negedge clk);
    check(do_en === 1'b1 && do_q === 1'b0, {"R3 dummy ", tag}, {do_en, do_q}, 2'b10);
    for (int k = 0; k < nw; k++) begin
      logic [15:0] got = '0;
      for (int b = 0; b < w; b++) begin
        bit_out(1'b0);
        got = {got[14:0], do_q};
      end
      check(got === exp_word(x16, cur), {"R3 R4 data ", tag}, got, exp_word(x16, cur));
      cur = (cur + 1) % (x16 ? 128 : 256);
    end
    cs_low();
    check(do_en === 1'b0, {"R11 oe off ", tag}, do_en, 0);
  endtask

  task automatic do_write(input bit x16, input int a, input int d, input int lead, input int extra, input string tag);
    org16 = x16;
    send_cmd(2'b01, a, x16 ? ABITS - 1 : ABITS, lead);
    send_data(d, x16 ? 16 : 8);
    for (int i = 0; i < extra; i++) bit_out(1'b1);
    cs_low();
    wait_ready(tag);
    if (x16) begin
      mdl[2*a] = d[15:8]; mdl[2*a+1] = d[7:0];
    end else mdl[a] = d[7:0];
  endtask

  task automatic ext_cmd(input bit x16, input logic [1:0] sub);
    int aw = x16 ? ABITS - 1 : ABITS;
    org16 = x16;
    send_cmd(2'b00, int'(sub) << (aw - 2), aw, 0);
    cs_low();
  endtask

  initial begin
    void'($urandom(32'h5EE7));
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    check(do_en === 1'b0, "R11 reset oe", do_en, 0);

    // R8 erase-all after enable (R2 extended codes)
    ext_cmd(1'b1, 2'b11);
    org16 = 1'b1;
    send_cmd(2'b00, 7'b1000000, ABITS - 1, 0);
    cs_low();
    wait_ready("R8 erall");
    for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
    do_read(1'b1, 0, 2, "R8 erall");
    do_read(1'b1, 100, 1, "R8 erall");

    // R5 disabled: write ignored, no status
    ext_cmd(1'b1, 2'b00);
    send_cmd(2'b01, 5, ABITS - 1, 0);
    send_data(16'h1234, 16);
    cs_low();
    cs = 1'b1;
    wait_clk(PHASE);
    check(do_en === 1'b0, "R5 no prog status", do_en, 0);
    cs_low();
    do_read(1'b1, 5, 1, "R5 unchanged");
    send_cmd(2'b00, 7'b1000000, ABITS - 1, 0);
    cs_low();
    do_read(1'b1, 9, 1, "R5 erall ignored");

    // R1 leading zeros, R6 write
    ext_cmd(1'b1, 2'b11);
    do_write(1'b1, 5, 16'h1234, 3, 0, "R1 R6 lead");
    do_read(1'b1, 5, 1, "R1 R6");
    do_write(1'b1, 6, 16'hABCD, 0, 5, "R6 extra clocks");
    do_read(1'b1, 6, 1, "R6 extra");

    // R7 erase, then R4 sequential
    org16 = 1'b1;
    send_cmd(2'b11, 5, ABITS - 1, 0);
    cs_low();
    wait_ready("R7 erase");
    mdl[10] = 8'hFF; mdl[11] = 8'hFF;
    do_read(1'b1, 4, 4, "R7 R4 seq");

    // R4 wrap
    do_write(1'b1, 127, 16'h5A5A, 0, 0, "R4 top");
    do_write(1'b1, 0, 16'h0F0F, 0, 0, "R4 zero");
    do_read(1'b1, 127, 2, "R4 wrap");

    // R9 abort
    org16 = 1'b1;
    send_cmd(2'b01, 6, ABITS - 1, 0);
    send_data(16'h1111 >> 6, 10);
    cs_low();
    cs = 1'b1;
    wait_clk(PHASE);
    check(do_en === 1'b0, "R9 no prog", do_en, 0);
    cs_low();
    do_read(1'b1, 6, 1, "R9 kept");

    // R12 byte mode
    do_read(1'b0, 12, 3, "R12 bytes");
    do_write(1'b0, 13, 8'h3C, 0, 0, "R12 byte wr");
    do_read(1'b1, 6, 1, "R12 pairing");
    do_read(1'b0, 255, 2, "R12 R4 wrap");

    // R8 write-all in byte mode
    org16 = 1'b0;
    send_cmd(2'b00, 8'b01000000, ABITS, 0);
    send_data(8'h77, 8);
    cs_low();
    wait_ready("R8 wrall");
    for (int i = 0; i < 256; i++) mdl[i] = 8'h77;
    do_read(1'b1, 0, 1, "R8 wrall");
    do_read(1'b0, 201, 1, "R8 wrall");

    // random writes and reads
    for (int it = 0; it < 20; it++) begin
      bit x16 = 1'($urandom % 2);
      int a = x16 ? int'($urandom % 128) : int'($urandom % 256);
      int d = x16 ? int'($urandom % 65536) : int'($urandom % 256);
      do_write(x16, a, d, int'($urandom % 3), int'($urandom % 3), "R6 rand");
      do_read(x16, a, 2, "R6 R4 rand");
    end

    // R5 read still works after disable
    ext_cmd(1'b1, 2'b00);
    do_read(1'b1, 3, 1, "R5 read disabled");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule